// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that software drives through a small 32-bit register window. A control register enables one of eight active-low chip-select lines. A configuration register sets the clock polarity and phase, the bit order (set separately for the shifted-out and the shifted-in word), an 8- or 16-bit word size, and a five-bit divider code. The block does not divide the clock itself. It passes the divider code to an external rate generator, which returns `sck_tick`: a one-cycle pulse for every half period of SCK.

Software starts a transfer by writing the outgoing word to the data-out register. The block then exchanges that word with the slave in full duplex. When the exchange ends, it places the received word in the data-in register and sets a completion flag in the cause register. Software clears that flag by writing zero to the cause register. A timing register sets when MISO is captured: either on the sampling edge itself, or one system clock after it. The later point gives more margin for slow slave outputs.

Top module: `spi_regmaster`

## Requirements
- R1: After reset every `cs_n` line is high, `sck` and `mosi` are low, and every register reads zero except timing (0x18), which reads 0x40 because its sample field resets to 1.
- R2: Control register 0x00 holds the select enable in bit 0 and the line index in bits 4:2. While bit 0 is set only `cs_n[index]` is low; otherwise all lines are high.
- R3: Configuration register 0x04 reads back its fields: divider code in bits 4:0, 16-bit words in bit 5, CPOL in bit 11, CPHA in bit 12, transmit LSB-first in bit 13 and receive LSB-first in bit 14. Bits 4:0 also appear on `div_sel`.
- R4: When idle, `sck` sits at CPOL and ticks have no effect. A write to 0x08 while idle starts a transfer, and bit 31 of 0x00 reads 1 until it ends. During a transfer each tick toggles `sck` once, for a total of twice the word length.
- R5: `mosi` sends the word MSB-first, or LSB-first when bit 13 is set. With CPHA=0 the first bit is present before the first edge and each trailing edge moves to the next bit. With CPHA=1 each leading edge after the first moves to the next bit.
- R6: MISO is sampled on leading edges when CPHA=0 and on trailing edges when CPHA=1. The first bit received is the MSB of the result, or the LSB when bit 14 is set.
- R7: In 8-bit mode only bits 7:0 of data-out are sent, and data-in (0x0C) reads zero in bits 15:8. In 16-bit mode all 16 bits are exchanged.
- R8: One clock after the final edge (and after any pending delayed capture), the busy bit clears, data-in updates and bit 0 of cause register 0x10 reads 1.
- R9: Writing zero to 0x10 clears the completion flag and a nonzero write leaves it unchanged. If a completion and a clearing write fall in the same cycle, the flag is set.
- R10: Timing register 0x18 bits 7:6 choose the capture point. Values 0 and 1 capture MISO at the sampling edge. Values 2 and 3 capture it one clock later.
- R11: A write to 0x08 during a transfer is ignored: the register keeps its value and the transfer in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sck_tick | input | 1 | Half-period pulse from the external rate generator |
| div_sel | output | 5 | Divider code for the rate generator |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |

## Verification
The hardest case to reach is the delayed MISO capture landing in the same clock as the next edge or as the completion. That only happens when ticks arrive back to back and the final sample falls on the last edge (CPHA=1). The stimulus therefore runs transfers with tick gaps of one to four clocks, in all four modes and both bit orders, with both capture settings. MISO is fed either from random bits or from a loopback of MOSI, so that every captured bit can be traced.

// File: rtl/spi_regmaster.sv
module spi_regmaster #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              sck_tick,
  output logic [4:0]        div_sel,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [7:0]        cs_n
);
  localparam int MAXB = 16;
  localparam int CW   = $clog2(2*MAXB + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_CAUS = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_TIM  = ADDR_W'('h18);

  logic        cs_en;
  logic [2:0]  cs_idx;
  logic [4:0]  pre;
  logic        wide, cpol, cpha, txl, rxl;
  logic        x_wide, x_cpol, x_cpha, x_txl, x_rxl;
  logic [15:0] dout_q, din_q, rx;
  logic        done_q, busy, pend;
  logic [1:0]  tsel;
  logic [CW-1:0] d;
  logic [3:0]  pidx;

  logic [4:0]    nbits;
  logic [CW-1:0] d_end, ktx_raw, krx;
  logic [4:0]    ktx;
  logic [3:0]    ptx, prx;
  logic          finish, edge_ok, wr_dout;

  assign nbits   = x_wide ? 5'd16 : 5'd8;
  assign d_end   = {nbits, 1'b0};
  assign ktx_raw = x_cpha ? ((d == '0) ? '0 : (d - 1'b1) >> 1) : d >> 1;
  assign ktx     = (ktx_raw >= CW'(nbits)) ? nbits - 5'd1 : ktx_raw[4:0];
  assign ptx     = x_txl ? ktx[3:0] : 4'(nbits - 5'd1 - ktx);
  assign krx     = d >> 1;
  assign prx     = x_rxl ? krx[3:0] : 4'(nbits - 5'd1 - krx[4:0]);
  assign finish  = busy && d == d_end && !pend;
  assign edge_ok = busy && sck_tick && d < d_end;
  assign wr_dout = bus_we && bus_addr == A_DOUT;

  assign sck     = busy ? x_cpol ^ d[0] : cpol;
  assign mosi    = busy & dout_q[ptx];
  assign div_sel = pre;
  assign cs_n    = cs_en ? ~(8'b1 << cs_idx) : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_en <= 1'b0; cs_idx <= '0; pre <= '0;
      wide <= 1'b0; cpol <= 1'b0; cpha <= 1'b0; txl <= 1'b0; rxl <= 1'b0;
      x_wide <= 1'b0; x_cpol <= 1'b0; x_cpha <= 1'b0; x_txl <= 1'b0; x_rxl <= 1'b0;
      dout_q <= '0; din_q <= '0; rx <= '0; done_q <= 1'b0;
      busy <= 1'b0; pend <= 1'b0; pidx <= '0; d <= '0; tsel <= 2'd1;
    end else begin
      if (bus_we && bus_addr == A_CTRL) begin
        cs_en  <= bus_wdata[0];
        cs_idx <= bus_wdata[4:2];
      end
      if (bus_we && bus_addr == A_CFG) begin
        pre  <= bus_wdata[4:0];
        wide <= bus_wdata[5];
        cpol <= bus_wdata[11];
        cpha <= bus_wdata[12];
        txl  <= bus_wdata[13];
        rxl  <= bus_wdata[14];
      end
      if (bus_we && bus_addr == A_TIM) tsel <= bus_wdata[7:6];
      if (bus_we && bus_addr == A_CAUS && bus_wdata == '0) done_q <= 1'b0;
      if (finish) begin
        busy   <= 1'b0;
        done_q <= 1'b1;
        din_q  <= x_wide ? rx : {8'h00, rx[7:0]};
      end
      if (pend) begin
        rx[pidx] <= miso;
        pend     <= 1'b0;
      end
      if (edge_ok) begin
        d <= d + 1'b1;
        if (d[0] == x_cpha) begin
          if (tsel[1]) begin
            pend <= 1'b1;
            pidx <= prx;
          end else begin
            rx[prx] <= miso;
          end
        end
      end
      if (wr_dout && !busy) begin
        dout_q <= bus_wdata[15:0];
        busy   <= 1'b1;
        d      <= '0;
        x_wide <= wide; x_cpol <= cpol; x_cpha <= cpha; x_txl <= txl; x_rxl <= rxl;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {busy, 26'b0, cs_idx, 1'b0, cs_en};
      A_CFG:   bus_rdata = {17'b0, rxl, txl, cpha, cpol, 5'b0, wide, pre};
      A_DOUT:  bus_rdata = {16'b0, dout_q};
      A_DIN:   bus_rdata = {16'b0, din_q};
      A_CAUS:  bus_rdata = {31'b0, done_q};
      A_TIM:   bus_rdata = {24'b0, tsel, 6'b0};
      default: bus_rdata = '0;
    endcase
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1) else $error("more than one select low"); // R2
  AST_EDGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> d <= d_end) else $error("edge count overrun"); // R4
  AST_SCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !sck_tick |=> !busy || $stable(sck)) else $error("sck moved without tick"); // R4
  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q) else $error("no done flag at end"); // R8
  AST_NARROW_DIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !x_wide |-> din_q[15:8] == 8'h00) else $error("upper din bits set"); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_dout |=> $stable(dout_q)) else $error("data-out changed while busy"); // R11
endmodule

// File: tb/spi_regmaster_test.sv
module spi_regmaster_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        sck_tick = 1'b0, sck, mosi, miso;
  logic [4:0]  div_sel;
  logic [7:0]  cs_n;
  logic        loop = 1'b0, rbit = 1'b0;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  assign miso = loop ? mosi : rbit;
  always #(CLK_P/2) clk = ~clk;

  spi_regmaster uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_tick(sck_tick), .div_sel(div_sel),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  // behavioural reference state
  bit m_en, m_wide, m_cpol, m_cpha, m_txl, m_rxl, m_done, m_busy, m_pend;
  bit x_wide, x_cpol, x_cpha, x_txl, x_rxl;
  int m_idx, m_pre, m_tsel, m_d, m_pidx, prev_addr;
  bit [15:0] m_dout, m_din, m_rx;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nb(); return x_wide ? 16 : 8; endfunction
  function automatic bit exp_mosi();
    int k;
    if (!m_busy) return 1'b0;
    k = x_cpha ? ((m_d == 0) ? 0 : (m_d - 1) / 2) : m_d / 2;
    if (k > nb() - 1) k = nb() - 1;
    return m_dout[x_txl ? k : nb() - 1 - k];
  endfunction
  function automatic bit exp_sck(); return m_busy ? (x_cpol ^ m_d[0]) : m_cpol; endfunction
  function automatic logic [7:0] exp_cs(); return m_en ? ~(8'd1 << m_idx) : 8'hFF; endfunction
  function automatic logic [31:0] exp_rd(int a);
    case (a)
      'h00: return {m_busy, 26'b0, 3'(m_idx), 1'b0, m_en};
      'h04: return {17'b0, m_rxl, m_txl, m_cpha, m_cpol, 5'b0, m_wide, 5'(m_pre)};
      'h08: return {16'b0, m_dout};
      'h0C: return {16'b0, m_din};
      'h10: return {31'b0, m_done};
      'h18: return {24'b0, 2'(m_tsel), 6'b0};
      default: return 32'h0;
    endcase
  endfunction
  function automatic string rd_tag(int a);
    case (a)
      'h00: return "R2 ctrl read";  'h04: return "R3 cfg read";
      'h08: return "R11 dout read"; 'h0C: return "R6 din read";
      'h10: return "R8 cause read"; 'h18: return "R10 timing read";
      default: return "R1 unmapped read";
    endcase
  endfunction

  task automatic model_step(bit we, int a, int wd, bit tk, bit mi);
    bit ob = m_busy, op = m_pend, fin;
    int od = m_d, opi = m_pidx, ot = m_tsel, n = nb(), k, p;
    bit c_wide = m_wide, c_cpol = m_cpol, c_cpha = m_cpha, c_txl = m_txl, c_rxl = m_rxl;
    fin = ob && od == 2*n && !op;
    if (we) begin
      if (a == 'h00) begin m_en = wd[0]; m_idx = (wd >> 2) & 7; end
      if (a == 'h04) begin
        m_pre = wd & 31; m_wide = wd[5]; m_cpol = wd[11];
        m_cpha = wd[12]; m_txl = wd[13]; m_rxl = wd[14];
      end
      if (a == 'h18) m_tsel = (wd >> 6) & 3;
      if (a == 'h10 && wd == 0) m_done = 0;
    end
    if (fin) begin m_busy = 0; m_done = 1; m_din = x_wide ? m_rx : {8'h00, m_rx[7:0]}; end
    if (op) begin m_rx[opi] = mi; m_pend = 0; end
    if (ob && tk && od < 2*n) begin
      m_d = od + 1;
      if ((od % 2) == int'(x_cpha)) begin
        k = od / 2; p = x_rxl ? k : n - 1 - k;
        if (ot >= 2) begin m_pend = 1; m_pidx = p; end else m_rx[p] = mi;
      end
    end
    if (we && a == 'h08 && !ob) begin
      m_dout = wd[15:0]; m_busy = 1; m_d = 0;
      x_wide = c_wide; x_cpol = c_cpol; x_cpha = c_cpha; x_txl = c_txl; x_rxl = c_rxl;
    end
  endtask

  task automatic cyc(bit we, int a, int wd, bit tk);
    bit mi;
    @(negedge clk);
    chk("R4 sck", sck, exp_sck());
    chk("R5 mosi", mosi, exp_mosi());
    chk("R2 cs_n", cs_n, exp_cs());
    chk("R3 div_sel", div_sel, m_pre);
    chk(rd_tag(prev_addr), bus_rdata, exp_rd(prev_addr));
    rbit = 1'($urandom % 2);
    mi = loop ? exp_mosi() : rbit;
    bus_we = we; bus_addr = 6'(a); bus_wdata = wd; sck_tick = tk;
    prev_addr = a;
    model_step(we, a, wd, tk, mi);
  endtask

  task automatic rd(int a, output logic [31:0] v);
    cyc(0, a, 0, 0); #1; v = bus_rdata;
  endtask

  task automatic xfer(int val, int gap, int poke);
    cyc(1, 'h08, val, 0);
    for (int i = 0; i < 400 && m_busy; i++) begin
      if (i == poke) cyc(1, 'h08, 'hFFFF, (i % gap) == gap - 1);
      else cyc(0, (i % 7) * 4, 0, (i % gap) == gap - 1);
    end
    cyc(0, 'h10, 0, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    m_tsel = 1; prev_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd('h18, v); chk("R1 timing reset", v, 32'h40);
    rd('h04, v); chk("R1 cfg reset", v, 0);
    chk("R1 cs_n reset", cs_n, 8'hFF);
    chk("R1 sck reset", sck, 0);
    repeat (4) cyc(0, 0, 0, 1);             // R4 idle ticks ignored
    // R2 chip selects
    cyc(1, 'h00, 'h15, 0); cyc(0, 0, 0, 0); #1;
    chk("R2 select line 5", cs_n, 8'hDF);
    cyc(1, 'h00, 'h14, 0); cyc(0, 0, 0, 0); #1;
    chk("R2 enable clear", cs_n, 8'hFF);
    cyc(1, 'h00, 'h01, 0);
    // R3 configuration
    cyc(1, 'h04, 'h13, 0); cyc(0, 0, 0, 0); #1;
    chk("R3 div_sel", div_sel, 5'h13);
    // mode 0, 8 bit, loopback
    loop = 1'b1;
    xfer('hA5, 2, -1);
    rd('h0C, v); chk("R6 loopback msb", v, 'hA5);
    rd('h10, v); chk("R8 done flag", v, 1);
    rd('h00, v); chk("R4 busy clear", v[31], 0);
    // R9 clearing
    cyc(1, 'h10, 5, 0); rd('h10, v); chk("R9 nonzero write keeps", v, 1);
    cyc(1, 'h10, 0, 0); rd('h10, v); chk("R9 zero write clears", v, 0);
    // R5/R6 mixed order
    cyc(1, 'h04, 'h2000, 0);
    xfer('h01, 3, -1);
    rd('h0C, v); chk("R6 lsb tx msb rx", v, 'h80);
    // R7 narrow word
    cyc(1, 'h04, 'h0, 0);
    xfer('h3C5A, 2, -1);
    rd('h0C, v); chk("R7 upper din zero", v, 'h005A);
    // 16-bit mode 3
    cyc(1, 'h04, 'h1820, 0); cyc(0, 0, 0, 0); #1;
    chk("R4 idle at cpol", sck, 1);
    xfer('hBEEF, 2, -1);
    rd('h0C, v); chk("R7 16-bit word", v, 'hBEEF);
    // R10 delayed capture, mode 1
    cyc(1, 'h18, 'h80, 0);
    cyc(1, 'h04, 'h1020, 0);
    xfer('h1234, 2, -1);
    rd('h0C, v); chk("R10 delayed capture", v, 'h1234);
    // R11 write while busy
    xfer('h4321, 2, 5);
    rd('h08, v); chk("R11 dout kept", v, 'h4321);
    rd('h0C, v); chk("R11 transfer kept", v, 'h4321);
    // random MISO over all modes, orders, gaps and capture settings
    loop = 1'b0;
    for (int t = 0; t < 64; t++) begin
      int cfg = ((t & 3) << 11) | (((t >> 2) & 3) << 13) | (((t >> 4) & 1) << 5) | (t & 31);
      cyc(1, 'h18, ((t >> 5) & 1) ? 'h80 : 'h40, 0);
      cyc(1, 'h04, cfg, 0);
      cyc(1, 'h00, ((t % 8) << 2) | 1, 0);
      xfer($urandom & 'hFFFF, 1 + (t % 4), (t % 3 == 0) ? 4 : -1);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule